// File: doc/BRIEF.md
# SPI Reply Tag Scanner

This block sits behind a SPI master's receive shift register and interprets the bytes a slave returns after a command has been sent. The exact position of a framing tag in that reply is not fixed, so the scanner hunts for the tag instead of assuming an offset. It takes one byte per handshake on a valid/ready input. It reports one pass/fail result with an error code per transfer, and block payload bytes leave on a valid/ready output.

A transfer starts with a `go` pulse while the block is idle. The pulse latches the mode, the byte count, the CRC16 enable and the clockless flag. There are three modes. Register read: hunt for a start tag, take a 4-byte value and an optional 2-byte checksum. Block read: the payload is split into packets, and each packet has its own tag hunt and optional checksum. Write response: take four bytes and pick the status pair out of them. Back-pressure works like this. In register, hunt, checksum and write-response phases the input is always ready. While block payload bytes are passing through, `rx_ready` follows `dout_ready` and `dout_valid` follows `rx_valid`, so a byte is accepted on the input in exactly the cycle it is accepted on the output. No byte is buffered.

Top module: `spi_reply_scanner`

## Requirements
- R1: After reset `busy`, `done`, `rx_ready` and `dout_valid` are all 0. While idle no input byte is accepted.
- R2: In register mode (`mode`=0) every byte whose upper nibble is not 0xF is skipped. The first byte with upper nibble 0xF is the start tag. The next four bytes form `reg_value`, with the first received byte in bits 31:24.
- R3: In register mode, if none of the first WIN_BYTES (8) bytes is a start tag, the transfer ends with error code 1 (no tag) right after the eighth byte.
- R4: With `crc_on`, two more bytes follow the data, high byte first. They are compared with the CRC-ITU-T of the data bytes (polynomial 0x1021, seed 0xFFFF, MSB first, no final inversion). A mismatch ends the transfer with error code 2.
- R5: In register mode with `clockless` set, the checksum bytes are still consumed but a mismatch is ignored.
- R6: In block mode (`mode`=1), `xfer_len` bytes are split into packets of PKT_BYTES, and the last packet may be shorter. Each packet begins with its own tag hunt, and its checksum is seeded afresh. Payload bytes appear on `dout_byte`, and `dout_last` is high only on the final byte of the transfer.
- R7: In block mode, a tag hunt that sees POLL_LIMIT (100) non-tag bytes ends the transfer with error code 1.
- R8: During block payload, `rx_ready` is 0 whenever `dout_valid` is high and `dout_ready` is low.
- R9: In write-response mode (`mode`=2 or 3), four bytes are taken, indexed 0..3. Among indices 2, 1, 0, the highest one whose upper nibble is 0xC is chosen. The result passes if that byte's lower nibble is 0x3 and the byte at the next index is 0x00. Otherwise the error code is 3. If no index qualifies, the error code is 1.
- R10: `done` is a one-cycle pulse in the cycle after the last accepted byte. `ok` and `err_code` hold from then until the next `go`. `ok` is 1 exactly when `err_code` is 0.
- R11: A block-mode transfer with `xfer_len`=0 consumes no byte and signals `done` with `ok`=1 in the cycle after `go`.
- R12: `go` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start pulse, taken only when idle |
| mode | input | 2 | 0 register read, 1 block read, 2/3 write response |
| xfer_len | input | LEN_W | Block-mode byte count |
| crc_on | input | 1 | Checksum trailer present |
| clockless | input | 1 | Register read skips the checksum compare |
| busy | output | 1 | Transfer in progress |
| rx_valid | input | 1 | Received byte valid |
| rx_ready | output | 1 | Received byte accepted |
| rx_byte | input | 8 | Received byte |
| dout_valid | output | 1 | Block payload byte valid |
| dout_ready | input | 1 | Downstream accepts payload byte |
| dout_byte | output | 8 | Block payload byte |
| dout_last | output | 1 | Final payload byte of the transfer |
| reg_value | output | 32 | Captured register value |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Transfer passed |
| err_code | output | 2 | 0 none, 1 no tag, 2 checksum, 3 bad response |

## Verification
The result of every mode is due exactly one cycle after the rising edge that takes the last byte. For an empty block transfer it is due one cycle after the edge that takes `go`. The bench drives each byte at a falling edge and lets the rising edge take it, then reads `done`, `ok` and `err_code` 1 ns after the next falling edge, which is the only cycle where `done` may be high. One cycle later it confirms that the pulse has dropped. Streamed payload bytes are combinational with the accepted input byte, so the bench captures them in the same cycle it drives that byte, before the rising edge.

// File: rtl/rts_pkg.sv
package rts_pkg;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_NOTAG = 2'd1,
    ERR_CRC   = 2'd2,
    ERR_RESP  = 2'd3
  } rts_err_e;

  typedef enum logic [1:0] {
    MD_REG   = 2'd0,
    MD_BLOCK = 2'd1,
    MD_WRESP = 2'd2
  } rts_mode_e;

  localparam logic [3:0] NIB_DATA_TAG = 4'hF;
  localparam logic [3:0] NIB_RESP_TAG = 4'hC;
  localparam logic [3:0] NIB_LAST_PKT = 4'h3;
  localparam logic [15:0] CRC_SEED    = 16'hFFFF;
  localparam logic [15:0] CRC_POLY    = 16'h1021;

  function automatic rts_mode_e mode_decode(input logic [1:0] m);
    if (m[1])      return MD_WRESP;
    else if (m[0]) return MD_BLOCK;
    else           return MD_REG;
  endfunction

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] x;
    x = c ^ {d, 8'h00};
    for (int k = 0; k < 8; k++) begin
      x = x[15] ? ((x << 1) ^ CRC_POLY) : (x << 1);
    end
    return x;
  endfunction

endpackage

// File: rtl/rts_crc16.sv
module rts_crc16
  import rts_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        step,
  input  logic [7:0]  din,
  output logic [15:0] crc
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc <= CRC_SEED;
    else if (init) crc <= CRC_SEED;
    else if (step) crc <= crc_step(crc, din);
  end

endmodule

// File: rtl/rts_wresp_eval.sv
module rts_wresp_eval
  import rts_pkg::*;
(
  input  logic [3:0][7:0] win,
  output logic            found,
  output logic            good
);

  logic [1:0] sel;

  always_comb begin
    sel   = 2'd0;
    found = 1'b0;
    for (int i = 0; i < 3; i++) begin
      if (win[i][7:4] == NIB_RESP_TAG) begin
        sel   = 2'(i);
        found = 1'b1;
      end
    end
    good = found && (win[sel][3:0] == NIB_LAST_PKT) && (win[sel + 2'd1] == 8'h00);
  end

endmodule

// File: rtl/spi_reply_scanner.sv
module spi_reply_scanner
  import rts_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int PKT_BYTES  = 8192,
  parameter int WIN_BYTES  = 8,
  parameter int POLL_LIMIT = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [1:0]       mode,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic             crc_on,
  input  logic             clockless,
  output logic             busy,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic [7:0]       rx_byte,
  output logic             dout_valid,
  input  logic             dout_ready,
  output logic [7:0]       dout_byte,
  output logic             dout_last,
  output logic [31:0]      reg_value,
  output logic             done,
  output logic             ok,
  output logic [1:0]       err_code
);

  localparam int SCAN_MAX = (WIN_BYTES > POLL_LIMIT) ? WIN_BYTES : POLL_LIMIT;
  localparam int SCAN_W   = $clog2(SCAN_MAX + 1);
  localparam logic [LEN_W-1:0] PKT_L = LEN_W'(PKT_BYTES);
  localparam logic [LEN_W-1:0] REG_L = LEN_W'(4);

  typedef enum logic [2:0] {
    S_IDLE, S_HUNT, S_DATA, S_CRCH, S_CRCL, S_WCAP, S_FIN
  } st_e;

  st_e              st;
  rts_mode_e        md;
  logic             crc_en_q, ck_q;
  logic [SCAN_W-1:0] scan_cnt, scan_lim;
  logic [LEN_W-1:0] pk_left, rem, pkt_first;
  logic [7:0]       crc_hi;
  logic [2:0][7:0]  wwin;
  logic [1:0]       wcnt;
  logic             ok_q;
  rts_err_e         err_q;
  logic             hs, is_tag;
  logic [15:0]      crc_val;
  logic             w_found, w_good;
  logic             crc_bad;

  assign hs        = rx_valid && rx_ready;
  assign is_tag    = rx_byte[7:4] == NIB_DATA_TAG;
  assign scan_lim  = (md == MD_REG) ? SCAN_W'(WIN_BYTES) : SCAN_W'(POLL_LIMIT);
  assign pkt_first = (rem > PKT_L) ? PKT_L : rem;
  assign crc_bad   = ({crc_hi, rx_byte} != crc_val) && !((md == MD_REG) && ck_q);

  rts_crc16 u_crc (
    .clk  (clk),
    .rst_n(rst_n),
    .init (st == S_HUNT && hs && is_tag),
    .step (st == S_DATA && hs),
    .din  (rx_byte),
    .crc  (crc_val)
  );

  rts_wresp_eval u_weval (
    .win  ({rx_byte, wwin}),
    .found(w_found),
    .good (w_good)
  );

  always_comb begin
    unique case (st)
      S_HUNT, S_CRCH, S_CRCL, S_WCAP: rx_ready = 1'b1;
      S_DATA:  rx_ready = (md == MD_BLOCK) ? dout_ready : 1'b1;
      default: rx_ready = 1'b0;
    endcase
  end

  assign dout_valid = (st == S_DATA) && (md == MD_BLOCK) && rx_valid;
  assign dout_byte  = rx_byte;
  assign dout_last  = dout_valid && (rem == LEN_W'(1));
  assign busy       = st != S_IDLE;
  assign done       = st == S_FIN;
  assign ok         = ok_q;
  assign err_code   = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      md        <= MD_REG;
      crc_en_q  <= 1'b0;
      ck_q      <= 1'b0;
      scan_cnt  <= '0;
      pk_left   <= '0;
      rem       <= '0;
      crc_hi    <= '0;
      wwin      <= '0;
      wcnt      <= '0;
      reg_value <= '0;
      ok_q      <= 1'b0;
      err_q     <= ERR_NONE;
    end else begin
      unique case (st)
        S_IDLE: if (go) begin
          md        <= mode_decode(mode);
          crc_en_q  <= crc_on;
          ck_q      <= clockless;
          rem       <= xfer_len;
          scan_cnt  <= '0;
          wcnt      <= '0;
          reg_value <= '0;
          ok_q      <= 1'b0;
          err_q     <= ERR_NONE;
          if (mode_decode(mode) == MD_WRESP) st <= S_WCAP;
          else if (mode_decode(mode) == MD_BLOCK && xfer_len == '0) begin
            st   <= S_FIN;
            ok_q <= 1'b1;
          end else st <= S_HUNT;
        end
        S_HUNT: if (hs) begin
          if (is_tag) begin
            st       <= S_DATA;
            scan_cnt <= '0;
            pk_left  <= (md == MD_REG) ? REG_L : pkt_first;
          end else if (scan_cnt == scan_lim - SCAN_W'(1)) begin
            st    <= S_FIN;
            err_q <= ERR_NOTAG;
          end else begin
            scan_cnt <= scan_cnt + SCAN_W'(1);
          end
        end
        S_DATA: if (hs) begin
          if (md == MD_REG) reg_value <= {reg_value[23:0], rx_byte};
          else              rem <= rem - LEN_W'(1);
          pk_left <= pk_left - LEN_W'(1);
          if (pk_left == LEN_W'(1)) begin
            if (crc_en_q) st <= S_CRCH;
            else if (md == MD_REG || rem == LEN_W'(1)) begin
              st   <= S_FIN;
              ok_q <= 1'b1;
            end else st <= S_HUNT;
          end
        end
        S_CRCH: if (hs) begin
          crc_hi <= rx_byte;
          st     <= S_CRCL;
        end
        S_CRCL: if (hs) begin
          if (crc_bad) begin
            st    <= S_FIN;
            err_q <= ERR_CRC;
          end else if (md == MD_REG || rem == '0) begin
            st   <= S_FIN;
            ok_q <= 1'b1;
          end else st <= S_HUNT;
        end
        S_WCAP: if (hs) begin
          if (wcnt == 2'd3) begin
            st    <= S_FIN;
            ok_q  <= w_good;
            err_q <= w_good ? ERR_NONE : (w_found ? ERR_RESP : ERR_NOTAG);
          end else begin
            wwin <= {rx_byte, wwin[2:1]};
            wcnt <= wcnt + 2'd1;
          end
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10: completion is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: pass flag agrees with error code when reported
  a_r10_ok_matches_err: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ok == (err_code == ERR_NONE)));

  // R8: a stalled output never lets an input byte through
  a_r8_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && !dout_ready) |-> !rx_ready);

  // R1: nothing is accepted while idle
  a_r1_idle_closed: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rx_ready);

  // R3 / R7: the tag hunt counter stays inside its window
  a_r3_scan_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HUNT) |-> (scan_cnt < scan_lim));

  // R12: a start pulse during a transfer does not restart it
  a_r12_go_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && go && !hs) |=> ($stable(md) && busy));

endmodule

// File: tb/spi_reply_scanner_tb.sv
`timescale 1ns/1ps
module spi_reply_scanner_tb;

  localparam int LEN_W = 16;
  localparam int PKT   = 8;

  logic clk = 0, rst_n = 0;
  logic go = 0, crc_on = 0, clockless = 0, rx_valid = 0, dout_ready = 1;
  logic [1:0] mode = 0;
  logic [LEN_W-1:0] xfer_len = 0;
  logic [7:0] rx_byte = 0;
  logic busy, rx_ready, dout_valid, dout_last, done, ok;
  logic [7:0] dout_byte;
  logic [31:0] reg_value;
  logic [1:0] err_code;

  always #2 clk = ~clk;

  spi_reply_scanner #(.LEN_W(LEN_W), .PKT_BYTES(PKT), .WIN_BYTES(8), .POLL_LIMIT(100)) u_dut (
    .clk(clk), .rst_n(rst_n), .go(go), .mode(mode), .xfer_len(xfer_len),
    .crc_on(crc_on), .clockless(clockless), .busy(busy),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_byte(rx_byte),
    .dout_valid(dout_valid), .dout_ready(dout_ready), .dout_byte(dout_byte),
    .dout_last(dout_last), .reg_value(reg_value), .done(done), .ok(ok), .err_code(err_code)
  );

  int total = 0, bad = 0;
  logic [7:0] stim[$], expd[$], got[$];
  bit gl[$];
  bit rdy_rand = 0, noise_go = 0;

  task automatic chk(input bit c, input string req, input longint act, input longint exp);
    total++;
    if (!c) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [7:0] q[$]);
    logic [15:0] c = 16'hFFFF;
    foreach (q[i]) begin
      for (int b = 7; b >= 0; b--) begin
        logic fb;
        fb = c[15] ^ q[i][b];
        c = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h1021;
      end
    end
    return c;
  endfunction

  function automatic logic [7:0] filler();
    return 8'($urandom) & 8'hEF;
  endfunction

  task automatic push_byte(input logic [7:0] b);
    int guard = 0;
    @(negedge clk);
    rx_valid = 1; rx_byte = b; go = noise_go;
    if (noise_go) mode = 2'd1;
    dout_ready = rdy_rand ? 1'($urandom % 2) : 1'b1;
    #1;
    while (!rx_ready && guard < 1000) begin
      if (dout_valid && !dout_ready) chk(!rx_ready, "R8 stalled input", rx_ready, 0);
      @(negedge clk);
      dout_ready = rdy_rand ? 1'($urandom % 2) : 1'b1;
      guard++;
      #1;
    end
    if (dout_valid && dout_ready) begin
      got.push_back(dout_byte);
      gl.push_back(dout_last);
    end
    @(posedge clk);
  endtask

  task automatic begin_xfer(input logic [1:0] m, input int len, input bit c, input bit ck);
    @(negedge clk);
    go = 1; mode = m; xfer_len = LEN_W'(len); crc_on = c; clockless = ck; rx_valid = 0;
    got.delete(); gl.delete();
    @(posedge clk);
  endtask

  task automatic send_all();
    foreach (stim[i]) push_byte(stim[i]);
  endtask

  task automatic finish_chk(input bit eok, input logic [1:0] eerr, input string req);
    @(negedge clk);
    rx_valid = 0; go = 0; noise_go = 0; dout_ready = 1;
    #1;
    chk(done === 1'b1, {req, " done due"}, done, 1);
    chk(ok == eok && err_code == eerr, {req, " result"}, {ok, err_code}, {eok, eerr});
    @(negedge clk);
    #1;
    chk(!done && !busy, "R10 pulse ends", {done, busy}, 0);
  endtask

  // register read: nfill fillers, data, optional checksum (corrupted if asked)
  task automatic reg_read(input int nfill, input logic [31:0] val, input bit c, input bit ck,
                          input bit corrupt, input string req);
    logic [7:0] d[$];
    logic [15:0] cc;
    stim.delete();
    for (int i = 0; i < nfill; i++) stim.push_back(filler());
    stim.push_back(8'hF0 | 8'($urandom % 16));
    for (int i = 3; i >= 0; i--) d.push_back(val[i*8 +: 8]);
    foreach (d[i]) stim.push_back(d[i]);
    cc = ref_crc(d) ^ (corrupt ? 16'h0101 : 16'h0);
    if (c) begin stim.push_back(cc[15:8]); stim.push_back(cc[7:0]); end
    begin_xfer(2'd0, 0, c, ck);
    send_all();
    if (c && corrupt && !ck) finish_chk(0, 2'd2, req);
    else begin
      finish_chk(1, 2'd0, req);
      chk(reg_value == val, {req, " value"}, reg_value, val);
    end
  endtask

  // block read with fillers per packet; bad_pkt >= 0 corrupts that packet's checksum
  task automatic blk_read(input int len, input bit c, input int bad_pkt, input string req);
    int left = len, p = 0;
    bit stop = 0;
    stim.delete(); expd.delete();
    while (left > 0 && !stop) begin
      logic [7:0] d[$];
      logic [15:0] cc;
      int n = (left > PKT) ? PKT : left;
      int nf = $urandom % 4;
      for (int i = 0; i < nf; i++) stim.push_back(filler());
      stim.push_back(8'hF3);
      for (int i = 0; i < n; i++) d.push_back(8'($urandom));
      foreach (d[i]) begin stim.push_back(d[i]); expd.push_back(d[i]); end
      cc = ref_crc(d) ^ ((p == bad_pkt) ? 16'h8000 : 16'h0);
      if (c) begin stim.push_back(cc[15:8]); stim.push_back(cc[7:0]); end
      if (c && p == bad_pkt) stop = 1;
      left -= n; p++;
    end
    begin_xfer(2'd1, len, c, 0);
    send_all();
    if (stop) finish_chk(0, 2'd2, req);
    else begin
      int mism = 0, lasts = 0;
      finish_chk(1, 2'd0, req);
      chk(got.size() == expd.size(), {req, " stream count"}, got.size(), expd.size());
      foreach (got[i]) begin
        if (i < expd.size() && got[i] != expd[i]) mism++;
        if (gl[i]) lasts++;
      end
      chk(mism == 0, {req, " stream bytes"}, mism, 0);
      chk(lasts == 1 && gl[gl.size()-1], {req, " last flag"}, lasts, 1);
    end
  endtask

  function automatic logic [1:0] wexp(input logic [7:0] w[4]);
    int idx = -1;
    for (int i = 2; i >= 0; i--) if (idx < 0 && w[i][7:4] == 4'hC) idx = i;
    if (idx < 0) return 2'd1;
    if (w[idx][3:0] == 4'h3 && w[idx+1] == 8'h00) return 2'd0;
    return 2'd3;
  endfunction

  task automatic wresp(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                       input logic [7:0] d, input string req);
    logic [7:0] w[4];
    logic [1:0] e;
    w[0] = a; w[1] = b; w[2] = c; w[3] = d;
    e = wexp(w);
    stim.delete();
    stim.push_back(a); stim.push_back(b); stim.push_back(c); stim.push_back(d);
    begin_xfer(2'd2, 0, 0, 0);
    send_all();
    finish_chk(e == 2'd0, e, req);
  endtask

  function automatic logic [7:0] wpick();
    case ($urandom % 4)
      0: return 8'hC3;
      1: return 8'h00;
      2: return 8'hC1;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL R10 watchdog act=hang exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk(!busy && !done && !rx_ready && !dout_valid, "R1 reset state",
        {busy, done, rx_ready, dout_valid}, 0);

    // R2 directed captures
    reg_read(3, 32'h12345678, 0, 0, 0, "R2 zero fill");
    reg_read(0, 32'hDEADBEEF, 0, 0, 0, "R2 no fill");
    reg_read(7, 32'hA5A5_0F0F, 0, 0, 0, "R3 tag at last slot");

    // R3 missing tag after eight fillers
    stim.delete();
    for (int i = 0; i < 8; i++) stim.push_back(8'h00);
    begin_xfer(2'd0, 0, 0, 0);
    send_all();
    finish_chk(0, 2'd1, "R3 no tag");

    // R4 / R5 checksum handling
    reg_read(2, 32'h0BADF00D, 1, 0, 0, "R4 crc good");
    reg_read(1, 32'h11223344, 1, 0, 1, "R4 crc bad");
    reg_read(1, 32'h55667788, 1, 1, 1, "R5 clockless ignores crc");

    // R12 start pulses during a busy register read
    noise_go = 1;
    reg_read(2, 32'hCAFEF00D, 0, 0, 0, "R12 go ignored");

    // R6 / R8 block reads
    blk_read(20, 1, -1, "R6 three packets crc");
    rdy_rand = 1;
    blk_read(17, 0, -1, "R8 backpressure");
    blk_read(24, 1, 1, "R6 bad second packet");
    rdy_rand = 0;
    blk_read(1, 1, -1, "R6 single byte");

    // R7 block hunt exhausts poll limit
    stim.delete();
    for (int i = 0; i < 100; i++) stim.push_back(filler());
    begin_xfer(2'd1, 4, 0, 0);
    send_all();
    finish_chk(0, 2'd1, "R7 poll limit");

    // R11 empty block
    begin_xfer(2'd1, 0, 0, 0);
    finish_chk(1, 2'd0, "R11 zero length");

    // R9 write-response directed
    wresp(8'hC1, 8'h00, 8'hC3, 8'h00, "R9 latest tag wins");
    wresp(8'hC3, 8'h00, 8'hC2, 8'h00, "R9 latest not last");
    wresp(8'h00, 8'h00, 8'h00, 8'hC3, "R9 no candidate");
    wresp(8'hC3, 8'h00, 8'hFF, 8'hFF, "R9 first slot");
    wresp(8'h11, 8'hC3, 8'h05, 8'h00, "R9 bad status");

    // mixed random traffic
    for (int it = 0; it < 60; it++) begin
      case ($urandom % 3)
        0: begin
          bit c = 1'($urandom), ck = 1'($urandom), cr = 1'($urandom);
          reg_read($urandom % 8, $urandom, c, ck, c & cr, "R2 random reg");
        end
        1: begin
          rdy_rand = 1'($urandom);
          blk_read(1 + $urandom % 30, 1'($urandom), -1, "R6 random block");
          rdy_rand = 0;
        end
        default: wresp(wpick(), wpick(), wpick(), wpick(), "R9 random");
      endcase
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule